// File: doc/BRIEF.md
# Time-of-Day Counter with Interval Alarm

This block keeps wall-clock time from a fixed-rate tick pulse that arrives once per hundredth of a second. Four chained counters hold hundredths, seconds, minutes and hours. A counter advances only when the one below it rolls over. The hour counter has two modes. In day mode it wraps after 23. In free mode it wraps after 255.

An interval alarm counts rollovers of one chosen time unit. When its count reaches a programmed target, it sets a sticky status flag. If the interrupt enable is set, the flag also drives an interrupt line. The alarm can be single-shot, where it stops after the match, or repeating, where it restarts from zero.

Software reaches the block through a small register port with a write strobe, a write address, a read address and a registered read-data output. Two synchronous resets are provided. The power-on reset clears everything. The core reset spares the time in day mode, so the clock keeps running across it.

Top module: `tic_top`

## Requirements
- R1: After a power-on reset, every register reads 0 and `irq` is low. The register addresses are 0 control, 1 interval target, 2 hundredths, 3 seconds, 4 minutes and 5 hours.
- R2: Control bit 0 (count enable) gates counting. While it is set, each `tick` adds one to hundredths. Hundredths wraps from 99 to 0 and carries into seconds. Seconds and minutes each wrap from 59 to 0 and carry into the next unit.
- R3: While count enable is clear, ticks are ignored and all four time registers hold their values.
- R4: When control bit 7 (day mode) is set, hours wrap from 23 to 0. When it is clear, hours wrap from 255 to 0.
- R5: When control bit 1 (alarm enable) is set, the alarm count advances once per rollover of the unit chosen by control bits [4:3]. The codes are 0 hundredths, 1 seconds, 2 minutes and 3 hours. Rollovers of any other unit do not advance it. When the count reaches the target, control bit 5 (flag) is set.
- R6: Control bit 2 selects the repeat mode. When it is set, the count restarts from zero after a match and matches again after the same number of rollovers. When it is clear, the alarm stops after a match until alarm enable is cleared and set again.
- R7: The flag stays set until the control register is written with bit 5 at 0. Writing bit 5 as 1 never sets the flag.
- R8: `irq` is high in the cycle after the flag and control bit 6 (interrupt enable) are both set. Otherwise it is low.
- R9: A core reset clears the control register, the target, the flag and the alarm count. In day mode it leaves the time registers, the day mode bit and count enable unchanged, and counting continues. Outside day mode it clears the time registers as well.
- R10: A write to a time register loads the written value. If a tick arrives in the same cycle, the carry produced by the old value still propagates to the higher units.
- R11: Clearing alarm enable resets the alarm count to zero. After alarm enable is set again, the full target number of rollovers is needed before the next match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| rst | input | 1 | Core reset, synchronous, active high |
| tick | input | 1 | One-cycle pulse per hundredth of a second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data, one cycle after the address |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that both resets are synchronous and last at least one clock. They also assume that `wr_addr` matters only while `wr_en` is high, and that every property stays quiet while a reset is active.

The stimulus holds `tick` low during most register writes, so directed reads can be checked against constant values. One cycle deliberately combines a time-register write with a tick, to exercise the carry-preservation rule.

Alarm tests move the time forward only by whole numbers of ticks. Because of this, the number of chosen-unit rollovers in each window is exact.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int unsigned AW = 3;
  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_IVAL = 3'd1;
  localparam logic [AW-1:0] A_HUND = 3'd2;
  localparam logic [AW-1:0] A_SEC  = 3'd3;
  localparam logic [AW-1:0] A_MIN  = 3'd4;
  localparam logic [AW-1:0] A_HOUR = 3'd5;

  // control layout: [7] day mode, [6] irq enable, [5] flag (separate),
  // [4:3] unit select, [2] repeat, [1] alarm enable, [0] count enable
  typedef struct packed {
    logic       d24;
    logic       irq_en;
    logic [1:0] unit;
    logic       auto_rep;
    logic       ival_en;
    logic       cnt_en;
  } ctrl_t;
endpackage

// File: rtl/tic_digit.sv
module tic_digit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] lim,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] val,
  output logic         carry
);
  // carry is taken from the value held before this edge
  assign carry = inc && (val >= lim);

  always_ff @(posedge clk) begin
    if (clr)      val <= '0;
    else if (ld)  val <= ld_val;
    else if (inc) val <= carry ? '0 : val + 1'b1;
  end
endmodule

// File: rtl/tic_interval.sv
module tic_interval #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         en,
  input  logic         step,
  input  logic         auto_rep,
  input  logic [W-1:0] target,
  output logic         match
);
  logic [W-1:0] cnt;
  logic [W-1:0] nxt;
  logic         halted;

  assign nxt   = cnt + 1'b1;
  assign match = en && step && !halted && (nxt == target);

  always_ff @(posedge clk) begin
    if (clr || !en) begin
      cnt    <= '0;
      halted <= 1'b0;
    end else if (step && !halted) begin
      if (match) begin
        cnt    <= auto_rep ? '0 : nxt;
        halted <= !auto_rep;
      end else begin
        cnt <= nxt;
      end
    end
  end
endmodule

// File: rtl/tic_top.sv
module tic_top
  import tic_pkg::*;
#(
  parameter int DW           = 8,
  parameter int HUND_MAX     = 99,
  parameter int SEC_MAX      = 59,
  parameter int MIN_MAX      = 59,
  parameter int HOUR_DAY_MAX = 23
) (
  input  logic          clk,
  input  logic          por,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam int NU = 4;

  ctrl_t                  ctrl_q;
  logic [DW-1:0]          ival_q;
  logic                   flag_q;
  logic [NU-1:0][DW-1:0]  tval;
  logic [NU-1:0][DW-1:0]  lim;
  logic [NU-1:0]          inc;
  logic [NU-1:0]          carry;
  logic [NU-1:0]          ld;
  logic                   core_clr;
  logic                   time_clr;
  logic                   step;
  logic                   match;
  logic                   ctrl_wr;

  assign core_clr = por | rst;
  assign time_clr = por | (rst & ~ctrl_q.d24);
  assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);

  assign lim[0] = DW'(HUND_MAX);
  assign lim[1] = DW'(SEC_MAX);
  assign lim[2] = DW'(MIN_MAX);
  assign lim[3] = ctrl_q.d24 ? DW'(HOUR_DAY_MAX) : {DW{1'b1}};

  for (genvar i = 0; i < NU; i++) begin : g_unit
    localparam logic [AW-1:0] UADDR = A_HUND + AW'(i);
    assign ld[i] = wr_en && (wr_addr == UADDR);
    if (i == 0) begin : g_first
      assign inc[i] = tick & ctrl_q.cnt_en;
    end else begin : g_chain
      assign inc[i] = carry[i-1];
    end
    tic_digit #(.W(DW)) u_dig (
      .clk    (clk),
      .clr    (time_clr),
      .inc    (inc[i]),
      .lim    (lim[i]),
      .ld     (ld[i]),
      .ld_val (wr_data),
      .val    (tval[i]),
      .carry  (carry[i])
    );
  end

  assign step = carry[ctrl_q.unit];

  tic_interval #(.W(DW)) u_ival (
    .clk      (clk),
    .clr      (core_clr),
    .en       (ctrl_q.ival_en),
    .step     (step),
    .auto_rep (ctrl_q.auto_rep),
    .target   (ival_q),
    .match    (match)
  );

  always_ff @(posedge clk) begin
    if (por) begin
      ctrl_q <= '0;
    end else if (rst) begin
      ctrl_q        <= '0;
      ctrl_q.d24    <= ctrl_q.d24;
      ctrl_q.cnt_en <= ctrl_q.d24 & ctrl_q.cnt_en;
    end else if (ctrl_wr) begin
      ctrl_q.d24      <= wr_data[7];
      ctrl_q.irq_en   <= wr_data[6];
      ctrl_q.unit     <= wr_data[4:3];
      ctrl_q.auto_rep <= wr_data[2];
      ctrl_q.ival_en  <= wr_data[1];
      ctrl_q.cnt_en   <= wr_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (core_clr)                            ival_q <= '0;
    else if (wr_en && (wr_addr == A_IVAL))   ival_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (core_clr)                   flag_q <= 1'b0;
    else if (match)                 flag_q <= 1'b1;
    else if (ctrl_wr && !wr_data[5]) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (core_clr) irq <= 1'b0;
    else          irq <= flag_q & ctrl_q.irq_en;
  end

  always_ff @(posedge clk) begin
    if (core_clr) begin
      rd_data <= '0;
    end else begin
      unique case (rd_addr)
        A_CTRL:  rd_data <= DW'({ctrl_q.d24, ctrl_q.irq_en, flag_q, ctrl_q.unit,
                                 ctrl_q.auto_rep, ctrl_q.ival_en, ctrl_q.cnt_en});
        A_IVAL:  rd_data <= ival_q;
        A_HUND:  rd_data <= tval[0];
        A_SEC:   rd_data <= tval[1];
        A_MIN:   rd_data <= tval[2];
        A_HOUR:  rd_data <= tval[3];
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tic_checker.sv
module tic_checker
  import tic_pkg::*;
#(
  parameter int DW           = 8,
  parameter int HUND_MAX     = 99,
  parameter int HOUR_DAY_MAX = 23
) (
  input logic                 clk,
  input logic                 por,
  input logic                 rst,
  input logic                 tick,
  input logic                 wr_en,
  input logic [AW-1:0]        wr_addr,
  input logic                 ctrl_wr_clear,
  input logic                 cnt_en,
  input logic                 d24,
  input logic                 irq_en,
  input logic                 auto_rep,
  input logic                 flag,
  input logic                 match,
  input logic                 irq,
  input logic [3:0][DW-1:0]   tval
);
  AST_HUND_WRAP: assert property (@(posedge clk) disable iff (por || rst)
    (tick && cnt_en && !(wr_en && wr_addr == A_HUND)) |=> (tval[0] <= DW'(HUND_MAX))); // R2

  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (por || rst)
    (!cnt_en && !(wr_en && wr_addr >= A_HUND && wr_addr <= A_HOUR)) |=> $stable(tval)); // R3

  AST_DAY_HOURS: assert property (@(posedge clk) disable iff (por || rst)
    (d24 && tval[3] <= DW'(HOUR_DAY_MAX) && !(wr_en && wr_addr == A_HOUR))
      |=> (tval[3] <= DW'(HOUR_DAY_MAX))); // R4

  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (por || rst)
    match |=> flag); // R5

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (por || rst)
    (match && !auto_rep) |=> !match); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (por || rst)
    (flag && !ctrl_wr_clear) |=> flag); // R7

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (por || rst)
    (flag && irq_en) |=> irq); // R8

  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (por || rst)
    !(flag && irq_en) |=> !irq); // R8
endmodule

bind tic_top tic_checker #(.DW(DW), .HUND_MAX(HUND_MAX), .HOUR_DAY_MAX(HOUR_DAY_MAX)) u_chk (
  .clk           (clk),
  .por           (por),
  .rst           (rst),
  .tick          (tick),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .ctrl_wr_clear (ctrl_wr && !wr_data[5]),
  .cnt_en        (ctrl_q.cnt_en),
  .d24           (ctrl_q.d24),
  .irq_en        (ctrl_q.irq_en),
  .auto_rep      (ctrl_q.auto_rep),
  .flag          (flag_q),
  .match         (match),
  .irq           (irq),
  .tval          (tval)
);

// File: tb/tb_tic_top.sv
module tb_tic_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       rst = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // behavioural model state
  int m_h, m_s, m_mi, m_hr, m_ival, m_icnt;
  bit m_halted, m_flag, m_cen, m_ven, m_auto, m_ien, m_d24;
  int m_unit;
  int exp_rd, exp_irq;
  string exp_tag;
  bit primed = 1'b0;

  tic_top dut (
    .clk(clk), .por(por), .rst(rst), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int mreg(int a);
    case (a)
      0: return (m_d24 << 7) | (m_ien << 6) | (m_flag << 5) | (m_unit << 3)
                | (m_auto << 2) | (m_ven << 1) | m_cen;
      1: return m_ival;
      2: return m_h;
      3: return m_s;
      4: return m_mi;
      5: return m_hr;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit inc0, c0, c1, c2, c3, stp, mt;
    int nh, ns, nmi, nhr, nx;
    primed <= 1'b1;
    if (por) begin
      m_h = 0; m_s = 0; m_mi = 0; m_hr = 0; m_ival = 0; m_icnt = 0;
      m_halted = 0; m_flag = 0; m_cen = 0; m_ven = 0; m_auto = 0; m_ien = 0;
      m_d24 = 0; m_unit = 0; exp_rd = 0; exp_irq = 0;
    end else if (rst) begin
      if (!m_d24) begin m_h = 0; m_s = 0; m_mi = 0; m_hr = 0; end
      m_cen = m_d24 && m_cen;
      m_ven = 0; m_auto = 0; m_ien = 0; m_unit = 0;
      m_ival = 0; m_icnt = 0; m_halted = 0; m_flag = 0;
      exp_rd = 0; exp_irq = 0;
    end else begin
      exp_rd  = mreg(int'(rd_addr));
      exp_irq = (m_flag && m_ien) ? 1 : 0;
      inc0 = tick && m_cen;
      c0 = inc0 && m_h >= 99;
      c1 = c0 && m_s >= 59;
      c2 = c1 && m_mi >= 59;
      c3 = c2 && m_hr >= (m_d24 ? 23 : 255);
      case (m_unit)
        0: stp = c0;
        1: stp = c1;
        2: stp = c2;
        default: stp = c3;
      endcase
      mt = 0;
      if (!m_ven) begin
        m_icnt = 0; m_halted = 0;
      end else if (stp && !m_halted) begin
        nx = (m_icnt + 1) % 256;
        if (nx == m_ival) begin
          mt = 1; m_icnt = m_auto ? 0 : nx; m_halted = !m_auto;
        end else m_icnt = nx;
      end
      nh  = inc0 ? (c0 ? 0 : m_h + 1) : m_h;
      ns  = c0 ? (c1 ? 0 : m_s + 1) : m_s;
      nmi = c1 ? (c2 ? 0 : m_mi + 1) : m_mi;
      nhr = c2 ? (c3 ? 0 : m_hr + 1) : m_hr;
      if (mt) m_flag = 1;
      else if (wr_en && wr_addr == 0 && !wr_data[5]) m_flag = 0;
      if (wr_en) begin
        case (wr_addr)
          0: begin
            m_d24 = wr_data[7]; m_ien = wr_data[6]; m_unit = int'(wr_data[4:3]);
            m_auto = wr_data[2]; m_ven = wr_data[1]; m_cen = wr_data[0];
          end
          1: m_ival = int'(wr_data);
          2: nh  = int'(wr_data);
          3: ns  = int'(wr_data);
          4: nmi = int'(wr_data);
          5: nhr = int'(wr_data);
          default: ;
        endcase
      end
      m_h = nh; m_s = ns; m_mi = nmi; m_hr = nhr;
    end
    case (rd_addr)
      3'd0: exp_tag = "R7";
      3'd1: exp_tag = "R5";
      3'd5: exp_tag = "R4";
      default: exp_tag = "R2";
    endcase
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (primed && !done) begin
      chk(exp_tag, int'(rd_data), exp_rd);
      chk("R8", int'(irq), exp_irq);
    end
  end

  task automatic finish_test();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, WATCHDOG);
      finish_test();
    end
  end

  task automatic cyc(bit t, bit we, int wa, int wd);
    @(negedge clk);
    tick = t; wr_en = we; wr_addr = 3'(wa); wr_data = 8'(wd);
  endtask

  task automatic wr(int a, int d);
    cyc(0, 1, a, d);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
  endtask

  task automatic rdchk(string req, int a, int exp);
    @(negedge clk);
    tick = 0; wr_en = 0; rd_addr = 3'(a);
    @(negedge clk);
    chk(req, int'(rd_data), exp);
  endtask

  task automatic core_rst();
    @(negedge clk);
    tick = 0; wr_en = 0; rst = 1;
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por = 0;
    // R1 reset state
    for (int a = 0; a < 6; a++) rdchk("R1", a, 0);
    chk("R1", int'(irq), 0);

    // R2 counting and carries
    wr(0, 8'h01);
    ticks(250);
    rdchk("R2", 2, 50);
    rdchk("R2", 3, 2);

    // R3 count enable clear
    wr(0, 8'h00);
    ticks(20);
    rdchk("R3", 2, 50);
    rdchk("R3", 3, 2);

    // R10 write colliding with a tick keeps the carry
    wr(0, 8'h01);
    wr(3, 59);
    wr(2, 99);
    cyc(1, 1, 2, 30);
    rdchk("R10", 2, 30);
    rdchk("R10", 3, 0);
    rdchk("R10", 4, 1);

    // R4 free-running hours
    wr(5, 255); wr(4, 59); wr(3, 59); wr(2, 99);
    ticks(1);
    rdchk("R4", 5, 0);
    rdchk("R2", 4, 0);
    // R4 day mode hours
    wr(0, 8'h81);
    wr(5, 23); wr(4, 59); wr(3, 59); wr(2, 99);
    ticks(1);
    rdchk("R4", 5, 0);

    // R9 core reset in day mode keeps time and counting
    wr(5, 5);
    core_rst();
    rdchk("R9", 5, 5);
    rdchk("R9", 0, 8'h81);
    ticks(1);
    rdchk("R9", 2, 1);
    wr(0, 8'h01);
    core_rst();
    rdchk("R9", 5, 0);
    rdchk("R9", 0, 0);

    // R5 alarm on hundredths rollover, single shot
    wr(1, 2);
    wr(0, 8'h43);
    ticks(199);
    rdchk("R5", 0, 8'h43);
    ticks(1);
    rdchk("R5", 0, 8'h63);
    chk("R8", int'(irq), 1);

    // R7 sticky flag
    wr(0, 8'h63);
    rdchk("R7", 0, 8'h63);
    wr(0, 8'h43);
    rdchk("R7", 0, 8'h43);
    chk("R8", int'(irq), 0);
    wr(0, 8'h63);
    rdchk("R7", 0, 8'h43);

    // R6 single shot stays halted
    ticks(300);
    rdchk("R6", 0, 8'h43);

    // R11 disabling the alarm resets its count
    wr(0, 8'h41); wr(0, 8'h43);
    ticks(100);
    wr(0, 8'h41); wr(0, 8'h43);
    ticks(100);
    rdchk("R11", 0, 8'h43);
    ticks(100);
    rdchk("R11", 0, 8'h63);

    // R6 repeat mode
    wr(0, 8'h45); wr(0, 8'h47);
    ticks(200);
    rdchk("R6", 0, 8'h67);
    wr(0, 8'h47);
    ticks(200);
    rdchk("R6", 0, 8'h67);

    // R5 seconds rollover select
    wr(0, 8'h00);
    wr(1, 1);
    wr(3, 58); wr(2, 99);
    wr(0, 8'h0B);
    ticks(1);
    rdchk("R5", 0, 8'h0B);
    wr(2, 99);
    ticks(1);
    rdchk("R5", 0, 8'h2B);

    // R5 hours rollover select
    wr(0, 8'h19);
    wr(0, 8'h1B);
    wr(5, 255); wr(4, 59); wr(3, 59); wr(2, 99);
    ticks(1);
    rdchk("R5", 0, 8'h3B);

    repeat (2) @(negedge clk);
    finish_test();
  end
endmodule